// File: doc/BRIEF.md
# Shadowed BCD Calendar Register Bank

This block keeps a calendar in packed BCD: seconds, minutes, hours (24-hour), day of week, date, month, two-digit year and a century flag. The counters that keep the time are held apart from eight byte-wide registers that a host reaches over a simple synchronous bus. These registers occupy the top eight locations of a 15-bit address space. A one-cycle `tick_1hz` pulse advances the counters by one second. In the following cycle all seven time registers are refreshed from the counters together, so the host never sees one field updated and another not yet updated.

The control register at offset 0 carries two halt bits. Setting the read-hold bit (D6) freezes the register copy so the host can read a consistent snapshot while the counters keep running. Setting the write-hold bit (D7) also freezes the copy, and the host then writes new values into the registers. Clearing D7 moves the registers into the counters in a single load cycle, and refreshing then resumes. The stop bit (seconds D7) and the century-enable bit (day D5) act on the counters as soon as they are written.

A small state machine sequences the bank through four states. RUN refreshes after every advance. HOLD_RD freezes the copy. HOLD_WR freezes the copy while the host loads values. LOAD is a single cycle in which the counters take the register values. The transitions are:
- RUN or HOLD_RD to HOLD_WR when D7 is set.
- RUN to HOLD_RD when only D6 is set.
- HOLD_RD to RUN when D6 clears.
- HOLD_WR to LOAD when D7 clears.
- LOAD to HOLD_WR, HOLD_RD or RUN, chosen by the control bits at that time.

Top module: `rtc_shadow_bank`

## Requirements
- R1: The bank answers when address bits 14..3 are all ones. The offset in bits 2..0 selects the register: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. `bus_rdata` and `bus_sel` are registered and describe the address presented one cycle earlier. For any other address `bus_sel` is 0, `bus_rdata` is 0, and writes change nothing.
- R2: The values after reset are control 00h, seconds 80h (stop set), minutes 00h, hours 00h, day 01h, date 01h, month 01h and year 00h.
- R3: Each advance adds one second in BCD. Seconds carry from 59 to 00 into minutes, minutes from 59 to 00 into hours, and hours from 23 to 00 into the date. The day of week (day bits 2..0) counts 1 to 7 and wraps from 7 to 1 at midnight.
- R4: The date wraps to 01 after the last day of the month and carries into the month. April, June, September and November have 30 days. February has 29 days when the BCD year is divisible by 4 (including 00) and 28 days otherwise. All other months have 31 days.
- R5: Month 12 carries into the year, and year 99 wraps to 00. On that wrap the century bit (day D4) inverts when century-enable (day D5) is 1 and stays unchanged when it is 0.
- R6: In RUN, the cycle after an advance copies all seven time registers from the counters at the same edge. Bits without a function read back as 0 after a copy. The control byte reads back exactly as written.
- R7: While control D6 is 1, the time registers hold their values across advances. A refresh due from an advance on the edge before the D6 write still lands. After D6 clears, the registers show the current counters within two cycles.
- R8: While control D7 is 1, no refresh takes place and the host may write the time registers. Clearing D7 loads the counters from registers 1 to 7, and the registers then show the loaded values.
- R9: While the stop bit (seconds D7) is 1, ticks do not advance the time. A write to the seconds register sets or clears the stop bit at once, whatever the state of D7.
- R10: A write to the day register sets century-enable at once, whatever the state of D7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, one per second |
| bus_addr | input | 15 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| bus_sel | output | 1 | Registered: the previous address hit the bank |

## Verification
A table of start times with expected results exercises each carry boundary:
- midnight with the day-of-week wrap,
- the end of February in leap and non-leap years, including year 00,
- the end of a 30-day month,
- the year wrap with the century bit enabled, disabled and already set.

A design with a wrong month-length table would land on a day 29, 30 or 31 that does not exist. A design that ignored century-enable would toggle the century bit when it should not.

Directed tests cover the following:
- an address that aliases the bank in its low bits;
- the stop bit after reset;
- a read hold that must leave the registers frozen while the counters keep running;
- an advance that lands just before the hold takes effect;
- a write hold followed by a load;
- century-enable written without the write-hold bit.

A design that refreshed during a hold, dropped the in-flight refresh, or failed to load on clearing D7 would return stale or moving seconds.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NREG  = 8;
    localparam int OFS_W = $clog2(NREG);

    typedef struct packed {
        logic       stop;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic       cen_en;
        logic       cen;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] year;
    } rtc_time_t;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_HOLD_RD,
        ST_HOLD_WR,
        ST_LOAD
    } rtc_state_t;

    localparam rtc_time_t RESET_TIME = '{
        stop: 1'b1, sec: 7'h00, min: 7'h00, hour: 6'h00,
        cen_en: 1'b0, cen: 1'b0, dow: 3'd1,
        date: 6'h01, mon: 5'h01, year: 8'h00
    };

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic is_leap(input logic [7:0] y);
        if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    function automatic logic [5:0] last_date(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    function automatic rtc_time_t step(input rtc_time_t t);
        rtc_time_t  n;
        logic [7:0] w;
        n = t;
        if (t.sec != 7'h59) begin
            w = bcd_inc({1'b0, t.sec});  n.sec = w[6:0];
        end else begin
            n.sec = 7'h00;
            if (t.min != 7'h59) begin
                w = bcd_inc({1'b0, t.min}); n.min = w[6:0];
            end else begin
                n.min = 7'h00;
                if (t.hour != 6'h23) begin
                    w = bcd_inc({2'b0, t.hour}); n.hour = w[5:0];
                end else begin
                    n.hour = 6'h00;
                    n.dow  = (t.dow == 3'd7) ? 3'd1 : t.dow + 3'd1;
                    if (t.date != last_date(t.mon, t.year)) begin
                        w = bcd_inc({2'b0, t.date}); n.date = w[5:0];
                    end else begin
                        n.date = 6'h01;
                        if (t.mon != 5'h12) begin
                            w = bcd_inc({3'b0, t.mon}); n.mon = w[4:0];
                        end else begin
                            n.mon = 5'h01;
                            if (t.year != 8'h99) begin
                                n.year = bcd_inc(t.year);
                            end else begin
                                n.year = 8'h00;
                                if (t.cen_en) n.cen = ~t.cen;
                            end
                        end
                    end
                end
            end
        end
        return n;
    endfunction

    function automatic logic [7:0] to_byte(input rtc_time_t t, input int idx);
        case (idx)
            1:       return {t.stop, t.sec};
            2:       return {1'b0, t.min};
            3:       return {2'b0, t.hour};
            4:       return {2'b0, t.cen_en, t.cen, 1'b0, t.dow};
            5:       return {2'b0, t.date};
            6:       return {3'b0, t.mon};
            7:       return t.year;
            default: return 8'h00;
        endcase
    endfunction

    function automatic rtc_time_t from_bytes(input logic [7:0] b1, input logic [7:0] b2,
                                             input logic [7:0] b3, input logic [7:0] b4,
                                             input logic [7:0] b5, input logic [7:0] b6,
                                             input logic [7:0] b7);
        rtc_time_t t;
        t.stop   = b1[7];    t.sec  = b1[6:0];
        t.min    = b2[6:0];  t.hour = b3[5:0];
        t.cen_en = b4[5];    t.cen  = b4[4];    t.dow = b4[2:0];
        t.date   = b5[5:0];  t.mon  = b6[4:0];  t.year = b7;
        return t;
    endfunction

endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  rtc_time_t load_img,
    input  logic      wr_stop,
    input  logic      stop_val,
    input  logic      wr_ceb,
    input  logic      ceb_val,
    output rtc_time_t cur,
    output logic      stepped
);

    assign stepped = tick && !cur.stop && !load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= RESET_TIME;
        end else if (load) begin
            cur <= load_img;
        end else begin
            if (stepped) cur <= step(cur);
            if (wr_stop) cur.stop   <= stop_val;
            if (wr_ceb)  cur.cen_en <= ceb_val;
        end
    end

    // R9: a stopped clock keeps its seconds across ticks
    a_r9_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.stop && !load) |=> $stable(cur.sec));

    // R5: century bit holds while its enable is clear
    a_r5_cen_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur.cen_en && !load) |=> $stable(cur.cen));

endmodule

// File: rtl/rtc_ctrl_fsm.sv
module rtc_ctrl_fsm
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_w,
    input  logic       ctrl_r,
    output rtc_state_t state,
    output logic       load,
    output logic       run
);

    rtc_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN, ST_HOLD_RD, ST_LOAD:
                nxt = ctrl_w ? ST_HOLD_WR : (ctrl_r ? ST_HOLD_RD : ST_RUN);
            ST_HOLD_WR:
                nxt = ctrl_w ? ST_HOLD_WR : ST_LOAD;
            default:
                nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        load = (state == ST_LOAD);
        run  = (state == ST_RUN);
    end

    // R8: clearing the write bit is followed by exactly one load cycle
    a_r8_clear_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD_WR && !ctrl_w) |=> (state == ST_LOAD));

    a_r8_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (state != ST_LOAD));

endmodule

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    output logic              bus_sel
);

    localparam int TAG_W = ADDR_W - OFS_W;

    logic [7:0]       regs [NREG];
    logic             hit, wr_hit, pend, copy, ld, run;
    logic [OFS_W-1:0] ofs;
    rtc_time_t        cur, load_img;
    rtc_state_t       state;
    logic             stepped;

    assign hit    = (bus_addr[ADDR_W-1:OFS_W] == {TAG_W{1'b1}});
    assign ofs    = bus_addr[OFS_W-1:0];
    assign wr_hit = hit && bus_we;
    assign copy   = pend && run;

    assign load_img = from_bytes(regs[1], regs[2], regs[3], regs[4],
                                 regs[5], regs[6], regs[7]);

    rtc_ctrl_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_w (regs[0][7]),
        .ctrl_r (regs[0][6]),
        .state  (state),
        .load   (ld),
        .run    (run)
    );

    rtc_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .load     (ld),
        .load_img (load_img),
        .wr_stop  (wr_hit && ofs == OFS_W'(1)),
        .stop_val (bus_wdata[7]),
        .wr_ceb   (wr_hit && ofs == OFS_W'(4)),
        .ceb_val  (bus_wdata[5]),
        .cur      (cur),
        .stepped  (stepped)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend && !copy) || stepped || ld;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[i] <= to_byte(RESET_TIME, i);
            else if (i != 0 && copy)
                regs[i] <= to_byte(cur, i);
            else if (wr_hit && ofs == OFS_W'(i))
                regs[i] <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= 8'h00;
            bus_sel   <= 1'b0;
        end else begin
            bus_rdata <= hit ? regs[ofs] : 8'h00;
            bus_sel   <= hit;
        end
    end

    logic [55:0] shadow_img;
    assign shadow_img = {regs[7], regs[6], regs[5], regs[4], regs[3], regs[2], regs[1]};

    // R7: a read hold keeps the time registers frozen unless the host writes them
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD_RD && !(wr_hit && ofs != '0)) |=> $stable(shadow_img));

    // R1: nothing outside the bank is reported as selected with data
    a_r1_quiet_unsel: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> (!bus_sel && bus_rdata == 8'h00));

endmodule

// File: tb/tb_rtc_shadow_bank.sv
`timescale 1ns/1ps
module tb_rtc_shadow_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic [14:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bus_sel;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    rtc_shadow_bank dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .bus_sel(bus_sel)
    );

    localparam int NV = 9;
    // {ticks, year, month, date, day, hour, min, sec}
    localparam logic [63:0] V_IN [NV] = '{
        64'h01_99_12_31_27_23_59_59,
        64'h01_24_02_28_03_23_59_59,
        64'h01_23_02_28_05_23_59_59,
        64'h01_10_04_30_06_23_59_59,
        64'h03_15_06_10_02_12_34_58,
        64'h01_00_02_29_01_23_59_59,
        64'h01_99_12_31_07_23_59_59,
        64'h01_99_12_31_37_23_59_59,
        64'h01_05_07_15_04_09_59_59
    };
    localparam logic [55:0] V_EXP [NV] = '{
        56'h00_01_01_31_00_00_00,
        56'h24_02_29_04_00_00_00,
        56'h23_03_01_06_00_00_00,
        56'h10_05_01_07_00_00_00,
        56'h15_06_10_02_12_35_01,
        56'h00_03_01_02_00_00_00,
        56'h00_01_01_01_00_00_00,
        56'h00_01_01_21_00_00_00,
        56'h05_07_15_04_10_00_00
    };
    localparam string V_TAG [NV] = '{"R5", "R4", "R4", "R4", "R3", "R4", "R5", "R5", "R3"};

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [14:0] a, output logic [7:0] d, output logic s);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata; s = bus_sel;
    endtask

    task automatic pulse(input int n);
        repeat (n) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
        idle(2);
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic read_check(input string tag, input logic [14:0] a, input logic [7:0] exp);
        logic [7:0] d; logic s;
        bus_read(a, d, s);
        check(tag, d, exp);
        check(tag, {7'b0, s}, 8'h01);
    endtask

    task automatic load_time(input logic [55:0] t);
        bus_write(15'h7FF8, 8'h80);
        for (int k = 1; k <= 7; k++) bus_write(15'h7FF8 + 15'(k), t[(k-1)*8 +: 8]);
        bus_write(15'h7FF8, 8'h00);
        idle(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d; logic s;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R2: reset values
        read_check("R2 ctrl",  15'h7FF8, 8'h00);
        read_check("R2 sec",   15'h7FF9, 8'h80);
        read_check("R2 min",   15'h7FFA, 8'h00);
        read_check("R2 hour",  15'h7FFB, 8'h00);
        read_check("R2 day",   15'h7FFC, 8'h01);
        read_check("R2 date",  15'h7FFD, 8'h01);
        read_check("R2 month", 15'h7FFE, 8'h01);
        read_check("R2 year",  15'h7FFF, 8'h00);

        // R1: aliasing address is not selected, and a write there has no effect
        bus_write(15'h3FF9, 8'h00);
        bus_read(15'h3FF9, d, s);
        check("R1 unsel data", d, 8'h00);
        check("R1 unsel sel", {7'b0, s}, 8'h00);
        bus_write(15'h7FF7, 8'hFF);
        bus_read(15'h7FF7, d, s);
        check("R1 below bank", {d[6:0], s}, 8'h00);
        // R9: stop set after reset, so a tick must not advance
        pulse(1);
        read_check("R9 stopped after reset", 15'h7FF9, 8'h80);

        // R9: direct stop clear without the write bit, then set again
        bus_write(15'h7FF9, 8'h00);
        pulse(1);
        read_check("R9 running after clear", 15'h7FF9, 8'h01);
        bus_write(15'h7FF9, 8'h80);
        pulse(1);
        read_check("R9 stopped again", 15'h7FF9, 8'h80);

        // R6: control byte reads back
        bus_write(15'h7FF8, 8'h25);
        read_check("R6 ctrl readback", 15'h7FF8, 8'h25);
        bus_write(15'h7FF8, 8'h00);
        idle(2);

        // vector table: R3, R4, R5 via R8 load and R6 refresh
        for (int v = 0; v < NV; v++) begin
            load_time(V_IN[v][55:0]);
            pulse(int'(V_IN[v][63:56]));
            for (int k = 1; k <= 7; k++)
                read_check(V_TAG[v], 15'h7FF8 + 15'(k), V_EXP[v][(k-1)*8 +: 8]);
        end

        // R10: century enable written without the write bit
        load_time(56'h99_12_31_07_23_59_59);
        bus_write(15'h7FFC, 8'h27);
        pulse(1);
        read_check("R10 ceb direct", 15'h7FFC, 8'h31);

        // R7: read hold freezes the registers, counters continue
        load_time(56'h15_06_10_02_12_00_00);
        bus_write(15'h7FF8, 8'h40);
        pulse(2);
        read_check("R7 held sec", 15'h7FF9, 8'h00);
        bus_write(15'h7FF8, 8'h00);
        idle(3);
        read_check("R7 caught up", 15'h7FF9, 8'h02);

        // R7: advance just before the hold takes effect still lands
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        bus_addr = 15'h7FF8; bus_wdata = 8'h40; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        pulse(1);
        read_check("R7 in-flight refresh", 15'h7FF9, 8'h03);
        bus_write(15'h7FF8, 8'h00);
        idle(3);
        read_check("R7 after release", 15'h7FF9, 8'h04);

        // R8: write hold blocks refresh, clearing loads the counters
        bus_write(15'h7FF8, 8'h80);
        bus_write(15'h7FF9, 8'h10);
        pulse(1);
        read_check("R8 held during write", 15'h7FF9, 8'h10);
        bus_write(15'h7FF8, 8'h00);
        idle(4);
        read_check("R8 loaded", 15'h7FF9, 8'h10);
        pulse(1);
        read_check("R8 runs from load", 15'h7FF9, 8'h11);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule